// File: doc/BRIEF.md
# Byte-Lane Static Memory Model with Dual Chip Select

A clocked, synthesizable functional stand-in for a 16-bit-wide asynchronous static RAM. It is meant for simulation and FPGA prototypes, where a real memory part is not available. The pin-level control set is kept: two chip selects of opposite polarity, an active-low write strobe, an active-low output enable and two active-low byte-lane enables. The controls are decoded into standby, idle, read and write operations. Writes and reads are byte-masked.

The bidirectional data bus is split into a data-in bus and a data-out bus. A two-bit lane-drive flag stands in for the three-state output driver: a lane whose flag is 0 is floating. The model reports that lane's data as zero. All controls are sampled on the rising clock edge, and read data appears after that edge. The address width is a parameter. `ADDR_W = 18` gives the full 262,144-word organisation, and the default is kept small so that elaboration stays light.

Top module: `bytelane_sram`

## Requirements
- R1: The array holds 2**ADDR_W independent 16-bit words (262,144 words when ADDR_W = 18). A word written at one address is unaffected by writes to other addresses.
- R2: The device counts as selected only when `cs_n` = 0 and `cs` = 1. After any edge with another combination, `mode` = 0 (standby) and `lane_drv` = 2'b00.
- R3: After an edge with both `ub_n` and `lb_n` high, `mode` = 0 (standby) and `lane_drv` = 2'b00, whatever the other controls are.
- R4: `lb_n` governs data bits 7..0 and `lane_drv[0]`. `ub_n` governs bits 15..8 and `lane_drv[1]`. A lane whose enable is high is neither written nor driven, and an undriven lane reads as zero on `rdata`.
- R5: On an edge where the device is selected and `we_n` = 0, each enabled lane of `addr` takes `wdata`. Afterwards `mode` = 3 (write) and `lane_drv` = 2'b00, regardless of `oe_n`.
- R6: On an edge where the device is selected, `we_n` = 1 and `oe_n` = 0, the stored word at `addr` appears on the enabled lanes of `rdata` right after that edge. In that case `mode` = 2 (read) and `lane_drv` = {~ub_n, ~lb_n}.
- R7: On an edge where the device is selected, `we_n` = 1 and `oe_n` = 1, the result is `mode` = 1 (active idle) and `lane_drv` = 2'b00.
- R8: Edges in standby (from R2 or R3) leave the stored contents unchanged, even with `we_n` = 0 and new data and address.
- R9: `rst_n` low clears `mode` to 0 and `lane_drv` to 2'b00 at once, without waiting for a clock edge. The memory contents are not initialised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset of mode and lane-drive state |
| addr | input | ADDR_W | Word address |
| cs_n | input | 1 | Active-low chip select |
| cs | input | 1 | Active-high chip select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable |
| ub_n | input | 1 | Active-low enable for bits 15..8 |
| lb_n | input | 1 | Active-low enable for bits 7..0 |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, zero on undriven lanes |
| lane_drv | output | 2 | Per-lane driver enable, bit 1 upper, bit 0 lower |
| mode | output | 2 | 0 standby, 1 active idle, 2 read, 3 write |

## Verification
A faulty control decode shows on `mode` and `lane_drv` at the very next edge, so every control combination is checked one edge after it is applied. Corrupted array contents show only on a later read. For that reason, each byte-masked write and each ignored standby write is followed by full-word and single-lane reads of the same address, and of a distant address, to catch lane swaps, missing masks and address aliasing.

// File: rtl/bytelane_sram.sv
module bytelane_sram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cs_n,
  input  logic              cs,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              ub_n,
  input  logic              lb_n,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        lane_drv,
  output logic [1:0]        mode
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HALF_W = DATA_W / 2;

  localparam logic [1:0] M_STBY  = 2'd0;
  localparam logic [1:0] M_IDLE  = 2'd1;
  localparam logic [1:0] M_READ  = 2'd2;
  localparam logic [1:0] M_WRITE = 2'd3;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic [1:0]        lane_en;
  logic              sel, do_wr, do_rd;
  logic [1:0]        mode_nx;

  assign lane_en = {~ub_n, ~lb_n};
  assign sel     = ~cs_n & cs & (|lane_en);
  assign do_wr   = sel & ~we_n;
  assign do_rd   = sel & we_n & ~oe_n;

  always_comb begin
    if (!sel)       mode_nx = M_STBY;
    else if (!we_n) mode_nx = M_WRITE;
    else if (!oe_n) mode_nx = M_READ;
    else            mode_nx = M_IDLE;
  end

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_lane
      always_ff @(posedge clk) begin
        if (do_wr && lane_en[g])
          mem[addr][g*HALF_W +: HALF_W] <= wdata[g*HALF_W +: HALF_W];
      end
      assign rdata[g*HALF_W +: HALF_W] = lane_drv[g] ? rd_q[g*HALF_W +: HALF_W] : '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (do_rd) rd_q <= mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= M_STBY;
      lane_drv <= 2'b00;
    end else begin
      mode     <= mode_nx;
      lane_drv <= do_rd ? lane_en : 2'b00;
    end
  end

  assert_standby_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !cs) |=> (mode == M_STBY && lane_drv == 2'b00));

  assert_standby_bytes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ub_n && lb_n) |=> (mode == M_STBY && lane_drv == 2'b00));

  assert_write_oe_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cs && !we_n && !(ub_n && lb_n)) |=> (mode == M_WRITE && lane_drv == 2'b00));

  assert_read_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cs && we_n && !oe_n && !(ub_n && lb_n)) |=>
      (mode == M_READ && lane_drv == {~$past(ub_n), ~$past(lb_n)}));

  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cs && we_n && oe_n && !(ub_n && lb_n)) |=> (mode == M_IDLE && lane_drv == 2'b00));

  assert_undriven_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_READ) |-> (lane_drv == 2'b00 && rdata == '0));
endmodule

// File: tb/bytelane_sram_test.sv
module bytelane_sram_test;
  localparam int AW = 10;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic cs_n = 1'b1, cs = 1'b0, we_n = 1'b1, oe_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0] lane_drv, mode;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  bytelane_sram #(.ADDR_W(AW), .DATA_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n), .cs(cs), .we_n(we_n),
    .oe_n(oe_n), .ub_n(ub_n), .lb_n(lb_n), .wdata(wdata), .rdata(rdata),
    .lane_drv(lane_drv), .mode(mode));

  // {addr, cs_n cs we_n oe_n ub_n lb_n, wdata, mode, lane_drv, rdata, req}
  localparam int NV = 16;
  localparam logic [55:0] VEC [NV] = '{
    {10'd5,    6'b010000, 16'hA1B2, 2'd3, 2'b00, 16'h0000, 4'd5},
    {10'd5,    6'b011000, 16'h0000, 2'd2, 2'b11, 16'hA1B2, 4'd6},
    {10'd5,    6'b010110, 16'h00CC, 2'd3, 2'b00, 16'h0000, 4'd4},
    {10'd5,    6'b011000, 16'h0000, 2'd2, 2'b11, 16'hA1CC, 4'd4},
    {10'd5,    6'b010001, 16'h7700, 2'd3, 2'b00, 16'h0000, 4'd4},
    {10'd5,    6'b011000, 16'h0000, 2'd2, 2'b11, 16'h77CC, 4'd4},
    {10'd5,    6'b011001, 16'h0000, 2'd2, 2'b10, 16'h7700, 4'd4},
    {10'd5,    6'b011010, 16'h0000, 2'd2, 2'b01, 16'h00CC, 4'd4},
    {10'd5,    6'b110000, 16'hFFFF, 2'd0, 2'b00, 16'h0000, 4'd2},
    {10'd5,    6'b000000, 16'hEEEE, 2'd0, 2'b00, 16'h0000, 4'd2},
    {10'd5,    6'b010011, 16'hDDDD, 2'd0, 2'b00, 16'h0000, 4'd3},
    {10'd5,    6'b011000, 16'h0000, 2'd2, 2'b11, 16'h77CC, 4'd8},
    {10'd5,    6'b011100, 16'h0000, 2'd1, 2'b00, 16'h0000, 4'd7},
    {10'd1023, 6'b010000, 16'h1234, 2'd3, 2'b00, 16'h0000, 4'd1},
    {10'd1023, 6'b011000, 16'h0000, 2'd2, 2'b11, 16'h1234, 4'd1},
    {10'd5,    6'b011000, 16'h0000, 2'd2, 2'b11, 16'h77CC, 4'd1}
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_all(input int req, input logic [1:0] em, input logic [1:0] ee,
                           input logic [15:0] ed);
    string t;
    t = $sformatf("R%0d", req);
    check({t, " mode"}, {14'd0, mode}, {14'd0, em});
    check({t, " lane_drv"}, {14'd0, lane_drv}, {14'd0, ee});
    check({t, " rdata"}, rdata, ed);
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R9: state while in reset
    #25;
    check_all(9, 2'd0, 2'b00, 16'h0000);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check_all(9, 2'd0, 2'b00, 16'h0000);
    for (int i = 0; i < NV; i++) begin
      logic [55:0] v;
      v = VEC[i];
      addr = v[55:46];
      {cs_n, cs, we_n, oe_n, ub_n, lb_n} = v[45:40];
      wdata = v[39:24];
      @(negedge clk);
      check_all(int'(v[3:0]), v[23:22], v[21:20], v[19:4]);
    end
    // R5: write with output enable high behaves the same
    addr = 10'd7; {cs_n, cs, we_n, oe_n, ub_n, lb_n} = 6'b010100; wdata = 16'h5A5A;
    @(negedge clk);
    check_all(5, 2'd3, 2'b00, 16'h0000);
    {cs_n, cs, we_n, oe_n, ub_n, lb_n} = 6'b011000;
    @(negedge clk);
    check_all(5, 2'd2, 2'b11, 16'h5A5A);
    // R9: reset during a read clears outputs without a clock edge
    #3 rst_n = 1'b0;
    #2;
    check_all(9, 2'd0, 2'b00, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    // R8/R1: contents survive reset and standby
    addr = 10'd5;
    @(negedge clk);
    check_all(8, 2'd2, 2'b11, 16'h77CC);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule